// File: doc/BRIEF.md
# Lens Command Repeater Bridge

This block sits between a small host register interface and an attached lens controller. The host loads a four-byte lens command one byte at a time, then sets a launch bit. The block streams the four bytes to the lens over a byte-wide valid/ready transmit channel. The order is command type, command code, first parameter, second parameter. Packed little-endian into a 32-bit word, the command type is the least significant byte.

After the last command byte is accepted, the block captures whatever the lens sends back on a byte-wide receive channel until an end-of-reply marker arrives. A reply may be any length, including zero bytes. The block keeps the first 63 bytes. The host polls one control register, which holds a completion flag and the number of captured bytes. It then drains the bytes, in arrival order, through a reply register.

The host bus has three registers. Address 0 is control/status, address 1 is the command byte register, and address 2 is the reply register. Address 3 is unused.

Top module: `lens_cmd_relay`

## Requirements
- R1: Successive writes to address 1 fill command bytes 0,1,2,3 in order. After launch, `tx_data` presents byte 0 first (the command type) and then bytes 1..3, advancing one byte per cycle in which `tx_valid` and `tx_ready` are both high.
- R2: When the block is idle, a write to address 0 with data bit 0 set starts a transfer. `tx_valid` is high from the next clock edge until the fourth byte is accepted. `tx_valid` is never high while the completion flag is set.
- R3: Control read bit 1 is the completion flag. It becomes 1 on the edge that samples `rx_end` while the block waits for a reply, and it returns to 0 on the edge that accepts a launch.
- R4: Control read bits 7:2 hold the captured reply byte count, and bit 0 reads 0. A launch clears the count to 0. A reply consisting only of `rx_end` is legal and completes with count 0.
- R5: While the completion flag is 1, each read of address 2 returns the next captured byte in arrival order, and reads beyond the count return 0. While the flag is 0, address 2 reads 0.
- R6: While a transfer is in progress, a launch request is ignored and writes to address 1 are ignored.
- R7: Reply bytes beyond 63 are discarded and the count stays at 63.
- R8: Bytes and `rx_end` on the receive channel are ignored unless the block is waiting for a reply.
- R9: After reset, control reads 0x00 and `tx_valid` is low.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged on the next cycle.
- R11: Address 1 and address 3 read as 0.
- R12: The byte carried on `rx_valid` in the same cycle as `rx_end` is part of the reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Register address (0 control, 1 command byte, 2 reply byte) |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read (advances the reply pointer) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, valid in the same cycle |
| tx_valid | output | 1 | Command byte available towards the lens |
| tx_ready | input | 1 | Lens accepts the presented command byte |
| tx_data | output | 8 | Command byte towards the lens |
| rx_valid | input | 1 | Reply byte from the lens is present |
| rx_data | input | 8 | Reply byte from the lens |
| rx_end | input | 1 | End of the lens reply |

## Verification
A wrong fill or send pointer shows as a misordered or duplicated byte on `tx_data`, within the four handshakes after launch. A stale count or completion flag shows in the first control read after launch or after `rx_end`. Such a read takes one cycle because read data is combinational. A wrong reply read pointer or a wrong saturation bound shows as a wrong byte, or as a nonzero pad value, within one reply drain, especially for zero-length replies and replies longer than 63 bytes.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
    typedef enum logic [1:0] {
        RLY_IDLE = 2'd0,
        RLY_SEND = 2'd1,
        RLY_WAIT = 2'd2
    } relay_state_t;

    localparam logic [1:0] LCR_ADDR_CTRL  = 2'd0;
    localparam logic [1:0] LCR_ADDR_CMD   = 2'd1;
    localparam logic [1:0] LCR_ADDR_REPLY = 2'd2;
endpackage

// File: rtl/lcr_cmd_stage.sv
module lcr_cmd_stage #(
    parameter int DATA_W    = 8,
    parameter int CMD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              restart,
    input  logic              advance,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_last
);
    localparam int IDX_W = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CMD_BYTES - 1);

    typedef struct packed {
        logic [CMD_BYTES-1:0][DATA_W-1:0] bytes;
        logic [IDX_W-1:0]                 fill;
        logic [IDX_W-1:0]                 send;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.fill = '0;
            st_d.send = '0;
        end else begin
            if (wr_en) begin
                st_d.bytes[st_q.fill] = wr_data;
                st_d.fill = (st_q.fill == LAST_IDX) ? '0 : st_q.fill + 1'b1;
            end
            if (advance) begin
                st_d.send = (st_q.send == LAST_IDX) ? '0 : st_q.send + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_byte = st_q.bytes[st_q.send];
    assign tx_last = (st_q.send == LAST_IDX);
endmodule

// File: rtl/lcr_reply_buf.sv
module lcr_reply_buf #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] head_byte
);
    localparam int DEPTH = (1 << CNT_W) - 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [CNT_W-1:0]             cnt;
        logic [CNT_W-1:0]             rptr;
    } rbuf_t;

    rbuf_t rb_d, rb_q;

    always_comb begin
        rb_d = rb_q;
        if (clear) begin
            rb_d.cnt  = '0;
            rb_d.rptr = '0;
        end else begin
            if (push && (rb_q.cnt != FULL)) begin
                rb_d.mem[rb_q.cnt] = push_data;
                rb_d.cnt = rb_q.cnt + 1'b1;
            end
            if (pop && (rb_q.rptr < rb_q.cnt)) begin
                rb_d.rptr = rb_q.rptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= rb_d;
    end

    assign count     = rb_q.cnt;
    assign head_byte = (rb_q.rptr < rb_q.cnt) ? rb_q.mem[rb_q.rptr] : '0;
endmodule

// File: rtl/lcr_relay_fsm.sv
module lcr_relay_fsm
    import lcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch_req,
    input  logic tx_ready,
    input  logic tx_last,
    input  logic rx_end,
    output logic accept,
    output logic idle,
    output logic tx_valid,
    output logic tx_fire,
    output logic capturing,
    output logic done
);
    typedef struct packed {
        relay_state_t state;
        logic         done;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        accept    = 1'b0;
        tx_valid  = 1'b0;
        tx_fire   = 1'b0;
        capturing = 1'b0;
        unique case (f_q.state)
            RLY_IDLE: begin
                if (launch_req) begin
                    accept    = 1'b1;
                    f_d.state = RLY_SEND;
                    f_d.done  = 1'b0;
                end
            end
            RLY_SEND: begin
                tx_valid = 1'b1;
                tx_fire  = tx_ready;
                if (tx_ready && tx_last) f_d.state = RLY_WAIT;
            end
            RLY_WAIT: begin
                capturing = 1'b1;
                if (rx_end) begin
                    f_d.state = RLY_IDLE;
                    f_d.done  = 1'b1;
                end
            end
            default: f_d.state = RLY_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.state <= RLY_IDLE;
            f_q.done  <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign idle = (f_q.state == RLY_IDLE);
    assign done = f_q.done;
endmodule

// File: rtl/lens_cmd_relay.sv
module lens_cmd_relay
    import lcr_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CMD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_end
);
    // Count occupies control bits above the flag and the launch bit.
    localparam int CNT_W = DATA_W - 2;

    logic             launch_req, cmd_wr, pop;
    logic             fsm_accept, fsm_idle, fsm_fire, fsm_capture, fsm_done;
    logic             stage_last;
    logic [CNT_W-1:0] rep_count;
    logic [DATA_W-1:0] rep_head;

    assign launch_req = host_wr && (host_addr == LCR_ADDR_CTRL) && host_wdata[0];
    assign cmd_wr     = host_wr && (host_addr == LCR_ADDR_CMD) && fsm_idle;
    assign pop        = host_rd && (host_addr == LCR_ADDR_REPLY) && fsm_done;

    lcr_relay_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_req(launch_req),
        .tx_ready  (tx_ready),
        .tx_last   (stage_last),
        .rx_end    (rx_end),
        .accept    (fsm_accept),
        .idle      (fsm_idle),
        .tx_valid  (tx_valid),
        .tx_fire   (fsm_fire),
        .capturing (fsm_capture),
        .done      (fsm_done)
    );

    lcr_cmd_stage #(.DATA_W(DATA_W), .CMD_BYTES(CMD_BYTES)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cmd_wr),
        .wr_data(host_wdata),
        .restart(fsm_accept),
        .advance(fsm_fire),
        .tx_byte(tx_data),
        .tx_last(stage_last)
    );

    lcr_reply_buf #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (fsm_accept),
        .push     (fsm_capture && rx_valid),
        .push_data(rx_data),
        .pop      (pop),
        .count    (rep_count),
        .head_byte(rep_head)
    );

    always_comb begin
        unique case (host_addr)
            LCR_ADDR_CTRL:  host_rdata = {rep_count, fsm_done, 1'b0};
            LCR_ADDR_REPLY: host_rdata = fsm_done ? rep_head : '0;
            default:        host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lcr_checker.sv
module lcr_checker #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        host_addr,
    input logic [DATA_W-1:0] host_rdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] tx_data,
    input logic              rx_valid,
    input logic              rx_end,
    input logic              done,
    input logic [CNT_W-1:0]  count,
    input logic              accept,
    input logic              capturing
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'((1 << CNT_W) - 1);

    assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_launch_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!done && count == '0));

    assert_done_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(capturing && rx_end));

    assert_no_tx_when_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tx_valid);

    assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (capturing && rx_valid && count == FULL) |=> (count == FULL));

    assert_reply_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == 2'd2 && !done) |-> (host_rdata == '0));

    assert_rx_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!capturing && !accept) |=> $stable(count));
endmodule

bind lens_cmd_relay lcr_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_rdata(host_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .rx_valid  (rx_valid),
    .rx_end    (rx_end),
    .done      (fsm_done),
    .count     (rep_count),
    .accept    (fsm_accept),
    .capturing (fsm_capture)
);

// File: tb/tb_lens_cmd_relay.sv
`timescale 1ns/1ps
module tb_lens_cmd_relay;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] host_addr;
    logic       host_wr, host_rd;
    logic [7:0] host_wdata, host_rdata;
    logic       tx_valid, tx_ready;
    logic [7:0] tx_data;
    logic       rx_valid, rx_end;
    logic [7:0] rx_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [7:0] rep [0:79];

    always #2.5 clk = ~clk;

    lens_cmd_relay dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end)
    );

    function automatic logic [7:0] exp_ctrl(input int len, input bit fin);
        int s = (len > 63) ? 63 : len;
        logic [5:0] c = s[5:0];
        return {c, fin, 1'b0};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic collect_tx(input logic [7:0] eb [4]);
        int got = 0;
        int guard = 0;
        while (got < 4 && guard < 400) begin
            @(negedge clk);
            tx_ready = 1'($urandom % 2);
            #1;
            if (tx_valid && tx_ready) begin
                check($sformatf("R1 tx byte %0d", got), tx_data, eb[got]);
                got++;
            end
            guard++;
        end
        @(negedge clk);
        tx_ready = 1'b0;
        if (got < 4) begin
            checks++; fails++;
            $display("FAIL R1 tx bytes actual=%0d expected=4", got);
        end
    endtask

    task automatic send_reply(input int len);
        for (int i = 0; i < len; i++) begin
            if ($urandom % 3 == 0) begin
                @(negedge clk); rx_valid = 1'b0; rx_end = 1'b0;
            end
            @(negedge clk);
            rx_valid = 1'b1; rx_data = rep[i]; rx_end = (i == len - 1);
        end
        if (len == 0) begin
            @(negedge clk); rx_valid = 1'b0; rx_end = 1'b1;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_end = 1'b0;
    endtask

    task automatic drain_reply(input int len);
        logic [7:0] d;
        int s = (len > 63) ? 63 : len;
        for (int i = 0; i < s + 2; i++) begin
            host_read(2'd2, d);
            if (i < s) check($sformatf("R5 reply byte %0d", i), d, rep[i]);
            else       check("R5 read past count", d, 8'h00);
        end
    endtask

    task automatic run_cmd(input logic [7:0] eb [4], input int len);
        logic [7:0] d;
        for (int i = 0; i < 4; i++) host_write(2'd1, eb[i]);
        host_write(2'd0, 8'h01);
        check("R2 tx_valid after launch", {7'd0, tx_valid}, 8'h01);
        collect_tx(eb);
        host_read(2'd0, d);
        check("R3 R4 ctrl while waiting", d, 8'h00);
        host_read(2'd2, d);
        check("R5 reply before done", d, 8'h00);
        for (int i = 0; i < len && i < 80; i++) rep[i] = 8'($urandom);
        send_reply(len);
        host_read(2'd0, d);
        check($sformatf("R4 R7 R12 ctrl after reply len %0d", len), d, exp_ctrl(len, 1'b1));
        drain_reply(len);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] cb [4];
        int unsigned seed;
        seed = $urandom(32'h1e45);
        rst_n = 1'b0; host_addr = 2'd0; host_wr = 0; host_rd = 0; host_wdata = 0;
        tx_ready = 0; rx_valid = 0; rx_end = 0; rx_data = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state, R11 unused reads
        host_read(2'd0, d);
        check("R9 ctrl after reset", d, 8'h00);
        check("R9 tx_valid after reset", {7'd0, tx_valid}, 8'h00);
        host_read(2'd1, d);
        check("R11 command reg reads zero", d, 8'h00);
        host_read(2'd3, d);
        check("R11 address 3 reads zero", d, 8'h00);

        // R8 receive traffic while idle is ignored
        rep[0] = 8'h77;
        send_reply(1);
        host_read(2'd0, d);
        check("R8 rx while idle", d, 8'h00);

        // directed: type byte first, zero-length, exact fill, overflow
        cb = '{8'h01, 8'h02, 8'h03, 8'h04};
        run_cmd(cb, 3);
        cb = '{8'hA5, 8'h5A, 8'h00, 8'hFF};
        run_cmd(cb, 0);
        run_cmd(cb, 63);
        run_cmd(cb, 64);
        run_cmd(cb, 75);

        // R6 launch and command write during a transfer are ignored
        cb = '{8'h11, 8'h22, 8'h33, 8'h44};
        for (int i = 0; i < 4; i++) host_write(2'd1, cb[i]);
        host_write(2'd0, 8'h01);
        host_write(2'd1, 8'hEE);
        host_write(2'd0, 8'h01);
        check("R10 tx_data held without ready", tx_data, 8'h11);
        collect_tx(cb);
        host_write(2'd0, 8'h01);
        check("R6 launch ignored while waiting", {7'd0, tx_valid}, 8'h00);
        rep[0] = 8'h9C; rep[1] = 8'h3D;
        send_reply(2);
        host_read(2'd0, d);
        check("R6 ctrl after ignored launches", d, exp_ctrl(2, 1'b1));
        drain_reply(2);

        // R8 receive traffic after completion is ignored
        rep[0] = 8'h55; rep[1] = 8'h66;
        send_reply(2);
        host_read(2'd0, d);
        check("R8 rx after done", d, exp_ctrl(2, 1'b1));
        check("R2 no tx while done", {7'd0, tx_valid}, 8'h00);

        // random commands and reply lengths
        for (int n = 0; n < 20; n++) begin
            for (int i = 0; i < 4; i++) cb[i] = 8'($urandom);
            run_cmd(cb, int'($urandom % 72));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule